// File: doc/BRIEF.md
# Dual-Pixel Output Bus-Inversion Encoder

This block sits on the output side of a display timing controller. It drives a 36-bit bus that carries two pixels per output clock: an odd pixel and an even pixel, each with 6-bit red, green and blue channels. Its purpose is to lower simultaneous switching on that bus, because switching adds to EMI. Each time a new word is loaded, the block compares the word it is about to drive with the word it drove last and counts the bits that differ. If 19 or more of the 36 bits would toggle, it drives the complement of the word and raises a flag. A receiver recovers the original pixels by XOR-ing every bit with that flag.

Upstream logic may hand over data that it has already inverted, and it marks such data with an input flag. The encoder first undoes that inversion and then applies its own decision. An enable input gates the function. When the enable is low, the restored data passes straight through and the output flag stays low. Words arrive at half the dot-clock rate. A load strobe marks the cycles that carry a new word, and the registered outputs hold their value between strobes.

Top module: `bus_invert_enc`

## Requirements
- R1: While reset is asserted, and on the first clock after it, all 36 output bits are 0 and `inv_out` is 0.
- R2: On a clock edge where `load` is 0, the data outputs and `inv_out` keep their previous values.
- R3: When `in_inv` is 1 on a load, the 36 input bits are complemented ("restored") before any encoding. When `in_inv` is 0, the data is used as given.
- R4: When `enc_en` is 0 on a load, the outputs take the restored word unchanged after the edge and `inv_out` is 0, however many bits toggle.
- R5: When `enc_en` is 1 on a load and the restored word differs from the currently driven 36-bit output in 19 or more bit positions, the outputs take the bitwise complement of the restored word and `inv_out` is 1.
- R6: When `enc_en` is 1 on a load and 18 or fewer bits differ, the outputs take the restored word and `inv_out` is 0. Exactly 18 differing bits is therefore not inverted.
- R7: The comparison reference is the word actually driven on the output pins, after any inversion, and not the previous input word.
- R8: After every load, each output bit XOR `inv_out` equals the corresponding restored input bit of that load.
- R9: With `enc_en` at 1, two consecutively driven words differ in at most 18 bits.
- R10: The 36-bit word packs the inputs as {odd R, odd G, odd B, even R, even G, even B}, most significant first, and the outputs use the same packing. The result appears on the clock edge that samples `load` (one register stage).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | New word present this cycle |
| enc_en | input | 1 | Enables the bus-inversion decision |
| in_inv | input | 1 | Incoming data is already complemented |
| odd_r | input | 6 | Odd pixel red in |
| odd_g | input | 6 | Odd pixel green in |
| odd_b | input | 6 | Odd pixel blue in |
| even_r | input | 6 | Even pixel red in |
| even_g | input | 6 | Even pixel green in |
| even_b | input | 6 | Even pixel blue in |
| q_odd_r | output | 6 | Odd pixel red out |
| q_odd_g | output | 6 | Odd pixel green out |
| q_odd_b | output | 6 | Odd pixel blue out |
| q_even_r | output | 6 | Even pixel red out |
| q_even_g | output | 6 | Even pixel green out |
| q_even_b | output | 6 | Even pixel blue out |
| inv_out | output | 1 | Driven word is complemented |

## Verification
The upstream restore and the toggle-threshold inversion can both act on the same word. When that happens, a complemented input is first undone and the result may then be complemented again. To provoke this, the stimulus raises `in_inv` on words whose restored form sits exactly at 18 and at 19 toggles from the driven word. Random traffic also sets the flag often together with wide toggle counts. For each such load, the check compares the flag with the toggle count of the restored word, not of the raw input, and confirms that XOR-ing the outputs with `inv_out` gives back the restored pixels.

// File: rtl/bus_invert_enc.sv
module bus_invert_enc #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          enc_en,
  input  logic          in_inv,
  input  logic [CW-1:0] odd_r,
  input  logic [CW-1:0] odd_g,
  input  logic [CW-1:0] odd_b,
  input  logic [CW-1:0] even_r,
  input  logic [CW-1:0] even_g,
  input  logic [CW-1:0] even_b,
  output logic [CW-1:0] q_odd_r,
  output logic [CW-1:0] q_odd_g,
  output logic [CW-1:0] q_odd_b,
  output logic [CW-1:0] q_even_r,
  output logic [CW-1:0] q_even_g,
  output logic [CW-1:0] q_even_b,
  output logic          inv_out
);

  localparam int W     = 6 * CW;
  localparam int CNT_W = $clog2(W + 1);
  localparam int HALF  = W / 2;

  logic [W-1:0]     raw, restored, drv, diff;
  logic [CNT_W-1:0] flips;
  logic             go_inv;

  assign raw      = {odd_r, odd_g, odd_b, even_r, even_g, even_b};
  assign restored = in_inv ? ~raw : raw;
  assign diff     = restored ^ drv;

  always_comb begin
    flips = '0;
    for (int i = 0; i < W; i++) flips = flips + CNT_W'(diff[i]);
  end

  assign go_inv = enc_en && (flips > CNT_W'(HALF));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv     <= '0;
      inv_out <= 1'b0;
    end else if (load) begin
      drv     <= go_inv ? ~restored : restored;
      inv_out <= go_inv;
    end
  end

  assign {q_odd_r, q_odd_g, q_odd_b, q_even_r, q_even_g, q_even_b} = drv;

  a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> (drv == '0 && !inv_out));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(drv) && $stable(inv_out)));

  a_r4_off_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !enc_en) |=> !inv_out);

  a_r8_decode: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ((drv ^ {W{inv_out}}) == $past(restored)));

  a_r9_toggle_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (load && enc_en) |=> ($countones(drv ^ $past(drv)) <= HALF));

endmodule

// File: tb/sim_bus_invert_enc.sv
module sim_bus_invert_enc;
  localparam int CW = 6;
  localparam int W  = 6 * CW;

  logic clk = 1'b0, rst_n = 1'b0, load = 1'b0, enc_en = 1'b0, in_inv = 1'b0;
  logic [W-1:0] din = '0;
  logic [CW-1:0] q0, q1, q2, q3, q4, q5;
  logic inv_out;
  logic [W-1:0] q;

  int n_chk = 0, n_bad = 0;
  logic [W-1:0] m_out = '0;
  logic m_inv = 1'b0;
  bit done = 0;

  always #4 clk = ~clk;

  bus_invert_enc #(.CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .load(load), .enc_en(enc_en), .in_inv(in_inv),
    .odd_r(din[35:30]), .odd_g(din[29:24]), .odd_b(din[23:18]),
    .even_r(din[17:12]), .even_g(din[11:6]), .even_b(din[5:0]),
    .q_odd_r(q0), .q_odd_g(q1), .q_odd_b(q2),
    .q_even_r(q3), .q_even_g(q4), .q_even_b(q5), .inv_out(inv_out));

  assign q = {q0, q1, q2, q3, q4, q5};

  function automatic int pop(input logic [W-1:0] v);
    int c = 0;
    for (int i = 0; i < W; i++) c += int'(v[i]);
    return c;
  endfunction

  function automatic logic [W-1:0] ones_low(input int n);
    logic [W-1:0] v = '0;
    for (int i = 0; i < n; i++) v[i] = 1'b1;
    return v;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic ld, input logic en, input logic ii,
                      input logic [W-1:0] d, input string tag);
    logic [W-1:0] r;
    @(negedge clk);
    load = ld; enc_en = en; in_inv = ii; din = d;
    r = ii ? ~d : d;
    if (ld) begin
      m_inv = en && (pop(r ^ m_out) >= 19);
      m_out = m_inv ? ~r : r;
    end
    @(posedge clk); #1;
    check({tag, " data"}, q, m_out);
    check({tag, " flag"}, W'(inv_out), W'(m_inv));
    if (ld) check("R8 decode", q ^ {W{inv_out}}, r);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(posedge clk); #1;
    check("R1 reset data", q, '0);
    check("R1 reset flag", W'(inv_out), '0);
    @(negedge clk); rst_n = 1'b1;

    step(1, 1, 0, ones_low(18), "R6 exactly 18");
    step(1, 1, 0, '0, "R6 back 18");
    step(1, 1, 0, ones_low(19), "R5 exactly 19");
    step(1, 1, 0, ones_low(19), "R7 ref is driven word");
    step(0, 1, 0, {W{1'b1}}, "R2 hold");
    step(1, 0, 0, {W{1'b1}} ^ m_out, "R4 disabled");
    step(1, 0, 0, '0, "R4 disabled again");
    step(1, 1, 1, ~ones_low(18), "R3 restore 18");
    step(1, 1, 1, ~(ones_low(18) ^ ones_low(37 - 18)), "R3 R5 restore 19");
    step(1, 1, 0, {6'h3F, 30'h0}, "R10 odd red field");
    step(1, 0, 0, {30'h0, 6'h2A}, "R10 even blue field");

    for (int k = 0; k < 400; k++) begin
      logic [W-1:0] d;
      d = {$urandom, $urandom};
      if (k % 5 == 0) d = m_out ^ ones_low(17 + ($urandom % 4));
      step(($urandom % 4) != 0, ($urandom % 5) != 0, $urandom % 2, d, "R5 R6 R3 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule